// File: doc/BRIEF.md
# AUX Reply Status Classifier

This block turns the completion status of one AUX channel transaction into a single result code and, for an acknowledged reply, hands the reply's data bytes to a caller buffer. A start strobe arms it. It then watches a done flag, a hot-plug-loss flag, two timeout flags, four receive framing-error flags and the reply byte count. When it reaches a decision, it raises a result-valid flag and holds the outcome there until the next start.

When the transaction finishes cleanly, the block reads byte 0 of the receive buffer. The upper nibble of that byte is the reply command. For an ACK, bytes 1 and up are streamed to the caller, one per cycle, through a write port, provided they fit the caller's stated capacity. A cycle counter bounds the wait for done. The line receiver that fills the buffer is outside the block, and so is the retry policy that acts on the result.

Top module: `aux_reply_classifier`

## Requirements
- R1: A start pulse is accepted only while the block is not waiting or copying. In the cycle after an accepted start, res_valid is 0. Once res_valid is 1, it stays 1 with res_code and data_cnt unchanged until the next accepted start. A start while busy has no effect on the result.
- R2: While waiting, hpd_lost=1 gives res_code 5 (disconnect) with data_cnt 0 in the next cycle. This holds whatever done and the other flags show.
- R3: With done=1, either rx_to_state or rx_to gives res_code 6 (timeout). This takes precedence over the framing flags.
- R4: With done=1 and no timeout flag, any of rx_bad_stop, rx_no_det, rx_bad_hi or rx_bad_lo gives res_code 7 (invalid reply). rx_min_viol is ignored.
- R5: With a clean done, a reply_cnt of 0, or one larger than BUF_DEPTH, gives res_code 7.
- R6: Otherwise the reply command is buf_data[7:4] of buffer byte 0. Command 0 maps to code 0 (ACK), 1 to code 1 (NACK), 2 to code 2 (DEFER), 4 to code 3 (I2C NACK) and 8 to code 4 (I2C DEFER). Every other command maps to code 7. The lower nibble is ignored.
- R7: On ACK, data_cnt is reply_cnt-1. Buffer bytes 1 to reply_cnt-1 appear on wr_data with wr_en=1 and wr_idx counting up from 0, one byte per cycle.
- R8: On ACK where reply_cnt-1 exceeds cap_bytes, the result is res_code 8 (overflow) with data_cnt 0, and wr_en never rises.
- R9: If neither done nor hpd_lost arrives within TMO_CYCLES cycles of waiting, the result is res_code 6.
- R10: Every result other than code 0 reports data_cnt 0, and no write takes place for it.
- R11: Timing of res_valid:
  - A non-copying decision made in the waiting cycle sets res_valid at the next clock edge.
  - An ACK with n data bytes sets res_valid n cycles after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Arms a new classification |
| done | input | 1 | Transaction complete |
| hpd_lost | input | 1 | Hot-plug loss seen |
| rx_to_state | input | 1 | Receiver in timeout state |
| rx_to | input | 1 | Receive timeout |
| rx_bad_stop | input | 1 | Invalid stop framing |
| rx_no_det | input | 1 | No reply detected |
| rx_bad_hi | input | 1 | Invalid high symbol |
| rx_bad_lo | input | 1 | Invalid low symbol |
| rx_min_viol | input | 1 | Minimum-count violation (ignored) |
| reply_cnt | input | CNT_W | Reply bytes received, header included |
| buf_addr | output | AW | Receive buffer read address |
| buf_data | input | 8 | Receive buffer read data (combinational) |
| cap_bytes | input | CNT_W | Caller buffer capacity in bytes |
| wr_en | output | 1 | Caller buffer write strobe |
| wr_idx | output | CNT_W | Caller buffer write index |
| wr_data | output | 8 | Caller buffer write data |
| res_valid | output | 1 | Result valid |
| res_code | output | 4 | Result code |
| data_cnt | output | CNT_W | Data bytes delivered |

## Verification
A wrong priority or a misdecoded nibble shows up as a wrong res_code at the edge right after done is seen. A stuck copy index shows up as a wrong wr_idx or wr_data within the burst, or as a late res_valid. The cycle on which res_valid rises is counted against the expected latency. A lost or runaway wait counter shows up as a timeout result at the wrong cycle, or as no result at all.

// File: rtl/aux_reply_classifier.sv
module aux_reply_classifier #(
  parameter int BUF_DEPTH  = 16,
  parameter int TMO_CYCLES = 200,
  localparam int CNT_W = $clog2(BUF_DEPTH + 1),
  localparam int AW    = $clog2(BUF_DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             done,
  input  logic             hpd_lost,
  input  logic             rx_to_state,
  input  logic             rx_to,
  input  logic             rx_bad_stop,
  input  logic             rx_no_det,
  input  logic             rx_bad_hi,
  input  logic             rx_bad_lo,
  input  logic             rx_min_viol,
  input  logic [CNT_W-1:0] reply_cnt,
  output logic [AW-1:0]    buf_addr,
  input  logic [7:0]       buf_data,
  input  logic [CNT_W-1:0] cap_bytes,
  output logic             wr_en,
  output logic [CNT_W-1:0] wr_idx,
  output logic [7:0]       wr_data,
  output logic             res_valid,
  output logic [3:0]       res_code,
  output logic [CNT_W-1:0] data_cnt
);
  localparam int TW = $clog2(TMO_CYCLES + 1);
  localparam logic [1:0] S_IDLE = 2'd0, S_WAIT = 2'd1, S_COPY = 2'd2;
  localparam logic [3:0] C_ACK = 4'd0, C_NACK = 4'd1, C_DEFER = 4'd2,
                         C_I2C_NACK = 4'd3, C_I2C_DEFER = 4'd4,
                         C_HPD = 4'd5, C_TMO = 4'd6, C_INV = 4'd7, C_OVF = 4'd8;

  logic [1:0]       st;
  logic [TW-1:0]    tmo;
  logic [CNT_W-1:0] idx, nbytes;

  logic             fin;
  logic             go_copy;
  logic [3:0]       dec_code;
  logic [CNT_W-1:0] n_data;
  logic             framing_err;
  logic             tmo_hit;
  logic             cnt_bad;

  assign framing_err = rx_bad_stop | rx_no_det | rx_bad_hi | rx_bad_lo;
  assign tmo_hit     = (tmo == TW'(TMO_CYCLES - 1));
  assign cnt_bad     = (reply_cnt == '0) || (reply_cnt > CNT_W'(BUF_DEPTH));
  assign n_data      = reply_cnt - CNT_W'(1);

  always_comb begin
    fin      = 1'b0;
    go_copy  = 1'b0;
    dec_code = C_INV;
    if (hpd_lost) begin
      fin = 1'b1; dec_code = C_HPD;
    end else if (done) begin
      fin = 1'b1;
      if (rx_to_state || rx_to)      dec_code = C_TMO;
      else if (framing_err)          dec_code = C_INV;
      else if (cnt_bad)              dec_code = C_INV;
      else begin
        unique case (buf_data[7:4])
          4'd0: begin
            if (n_data > cap_bytes)  dec_code = C_OVF;
            else if (n_data == '0)   dec_code = C_ACK;
            else begin
              fin = 1'b0; go_copy = 1'b1; dec_code = C_ACK;
            end
          end
          4'd1:    dec_code = C_NACK;
          4'd2:    dec_code = C_DEFER;
          4'd4:    dec_code = C_I2C_NACK;
          4'd8:    dec_code = C_I2C_DEFER;
          default: dec_code = C_INV;
        endcase
      end
    end else if (tmo_hit) begin
      fin = 1'b1; dec_code = C_TMO;
    end
  end

  assign buf_addr = (st == S_COPY) ? AW'(idx + CNT_W'(1)) : '0;
  assign wr_en    = (st == S_COPY);
  assign wr_idx   = idx;
  assign wr_data  = buf_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      tmo       <= '0;
      idx       <= '0;
      nbytes    <= '0;
      res_valid <= 1'b0;
      res_code  <= C_ACK;
      data_cnt  <= '0;
    end else begin
      unique case (st)
        S_IDLE: if (start) begin
          st        <= S_WAIT;
          tmo       <= '0;
          res_valid <= 1'b0;
        end
        S_WAIT: begin
          if (fin) begin
            st        <= S_IDLE;
            res_valid <= 1'b1;
            res_code  <= dec_code;
            data_cnt  <= (dec_code == C_ACK) ? n_data : '0;
          end else if (go_copy) begin
            st     <= S_COPY;
            idx    <= '0;
            nbytes <= n_data;
          end else begin
            tmo <= tmo + TW'(1);
          end
        end
        S_COPY: begin
          idx <= idx + CNT_W'(1);
          if (idx == nbytes - CNT_W'(1)) begin
            st        <= S_IDLE;
            res_valid <= 1'b1;
            res_code  <= C_ACK;
            data_cnt  <= nbytes;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  logic unused_ok;
  assign unused_ok = rx_min_viol ^ buf_data[3];
endmodule

// File: rtl/aux_reply_classifier_chk.sv
module aux_reply_classifier_chk #(
  parameter int CNT_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             hpd_lost,
  input logic [1:0]       st,
  input logic             wr_en,
  input logic [CNT_W-1:0] wr_idx,
  input logic [CNT_W-1:0] cap_bytes,
  input logic             res_valid,
  input logic [3:0]       res_code,
  input logic [CNT_W-1:0] data_cnt
);
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !start) |=> (res_valid && $stable(res_code) && $stable(data_cnt))); // R1
  AST_VALID_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (start && res_valid) |=> !res_valid); // R1
  AST_HPD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 2'd1 && hpd_lost) |=> (res_valid && res_code == 4'd5 && data_cnt == '0)); // R2
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_idx < cap_bytes)); // R8
  AST_NONACK_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_code != 4'd0) |-> (data_cnt == '0)); // R10
  AST_WRITE_BEFORE_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !res_valid); // R7
endmodule

bind aux_reply_classifier aux_reply_classifier_chk #(.CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .start(start), .hpd_lost(hpd_lost), .st(st),
  .wr_en(wr_en), .wr_idx(wr_idx), .cap_bytes(cap_bytes),
  .res_valid(res_valid), .res_code(res_code), .data_cnt(data_cnt)
);

// File: tb/aux_reply_classifier_tb.sv
module aux_reply_classifier_tb_top;
  localparam int DEPTH = 16;
  localparam int TMO   = 200;
  localparam int CW    = $clog2(DEPTH + 1);
  localparam int AW    = $clog2(DEPTH);

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, done = 1'b0, hpd_lost = 1'b0;
  logic rx_to_state = 1'b0, rx_to = 1'b0, rx_bad_stop = 1'b0, rx_no_det = 1'b0;
  logic rx_bad_hi = 1'b0, rx_bad_lo = 1'b0, rx_min_viol = 1'b0;
  logic [CW-1:0] reply_cnt = '0, cap_bytes = '0;
  logic [AW-1:0] buf_addr;
  logic [7:0]    buf_data;
  logic          wr_en, res_valid;
  logic [CW-1:0] wr_idx, data_cnt;
  logic [7:0]    wr_data;
  logic [3:0]    res_code;

  logic [7:0] rxm [DEPTH];
  logic [7:0] cmem [DEPTH];
  int n_wr = 0;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;
  assign buf_data = rxm[buf_addr];

  always @(posedge clk) if (wr_en) begin
    cmem[wr_idx] <= wr_data;
    n_wr <= n_wr + 1;
  end

  aux_reply_classifier #(.BUF_DEPTH(DEPTH), .TMO_CYCLES(TMO)) dut_i (.*);

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clr_flags();
    done = 0; hpd_lost = 0; rx_to_state = 0; rx_to = 0; rx_bad_stop = 0;
    rx_no_det = 0; rx_bad_hi = 0; rx_bad_lo = 0; rx_min_viol = 0;
  endtask

  // fires start with done already raised; returns edges until res_valid
  task automatic fire(output int lat);
    @(negedge clk); start = 1;
    @(negedge clk); start = 0; lat = 1;
    while (!res_valid && lat < TMO + 20) begin @(negedge clk); lat++; end
    clr_flags();
  endtask

  task automatic t_reset();
    chk("R1 reset valid", res_valid, 0);
    chk("R1 reset wr_en", wr_en, 0);
  endtask

  task automatic t_ack_data();
    int lat;
    rxm[0] = 8'h0F;
    for (int i = 1; i < DEPTH; i++) rxm[i] = 8'(8'h30 + i);
    n_wr = 0; reply_cnt = 5; cap_bytes = 4; done = 1; rx_min_viol = 1;
    fire(lat);
    chk("R6 ack code", res_code, 0);
    chk("R7 data_cnt", data_cnt, 4);
    chk("R7 writes", n_wr, 4);
    for (int i = 0; i < 4; i++) chk("R7 byte", cmem[i], 8'h31 + i);
    chk("R11 ack latency", lat, 2 + 4);
    chk("R4 min_viol ignored", res_code, 0);
  endtask

  task automatic t_ack_empty();
    int lat;
    rxm[0] = 8'h00; n_wr = 0; reply_cnt = 1; cap_bytes = 0; done = 1;
    fire(lat);
    chk("R7 ack empty code", res_code, 0);
    chk("R7 ack empty cnt", data_cnt, 0);
    chk("R11 latency", lat, 2);
  endtask

  task automatic t_codes();
    int lat;
    int cmd [6] = '{1, 2, 4, 8, 3, 15};
    int exp [6] = '{1, 2, 3, 4, 7, 7};
    for (int k = 0; k < 6; k++) begin
      rxm[0] = 8'((cmd[k] << 4) | 5); n_wr = 0; reply_cnt = 3; cap_bytes = 8; done = 1;
      fire(lat);
      chk("R6 decode", res_code, exp[k]);
      chk("R10 cnt zero", data_cnt, 0);
      chk("R10 no write", n_wr, 0);
      chk("R11 latency", lat, 2);
    end
  endtask

  task automatic t_priority();
    int lat;
    rxm[0] = 8'h00; reply_cnt = 3; cap_bytes = 8;
    done = 1; hpd_lost = 1; rx_to = 1; rx_bad_stop = 1; fire(lat);
    chk("R2 hpd wins", res_code, 5);
    hpd_lost = 1; fire(lat);
    chk("R2 hpd without done", res_code, 5);
    done = 1; rx_to_state = 1; rx_bad_lo = 1; fire(lat);
    chk("R3 timeout state", res_code, 6);
    done = 1; rx_to = 1; fire(lat);
    chk("R3 timeout flag", res_code, 6);
    done = 1; rx_bad_stop = 1; fire(lat); chk("R4 bad stop", res_code, 7);
    done = 1; rx_no_det = 1;   fire(lat); chk("R4 no det", res_code, 7);
    done = 1; rx_bad_hi = 1;   fire(lat); chk("R4 bad hi", res_code, 7);
    done = 1; rx_bad_lo = 1;   fire(lat); chk("R4 bad lo", res_code, 7);
    reply_cnt = 0; done = 1; fire(lat); chk("R5 empty", res_code, 7);
    reply_cnt = 17; done = 1; fire(lat); chk("R5 too long", res_code, 7);
  endtask

  task automatic t_overflow();
    int lat;
    rxm[0] = 8'h00; n_wr = 0; reply_cnt = 6; cap_bytes = 4; done = 1;
    fire(lat);
    chk("R8 overflow code", res_code, 8);
    chk("R8 overflow cnt", data_cnt, 0);
    chk("R8 no write", n_wr, 0);
  endtask

  task automatic t_no_done();
    int lat;
    clr_flags(); fire(lat);
    chk("R9 timeout code", res_code, 6);
    chk("R9 timeout latency", lat, 1 + TMO);
  endtask

  task automatic t_hold_busy();
    int lat;
    rxm[0] = 8'h20; reply_cnt = 2; cap_bytes = 4;
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    repeat (3) @(negedge clk);
    start = 1; @(negedge clk); start = 0;
    chk("R1 busy start ignored", res_valid, 0);
    done = 1; @(negedge clk); done = 0;
    chk("R1 result after busy", res_code, 2);
    chk("R1 valid", res_valid, 1);
    rxm[0] = 8'h10; hpd_lost = 1;
    repeat (5) @(negedge clk);
    hpd_lost = 0;
    chk("R1 hold code", res_code, 2);
    chk("R1 hold valid", res_valid, 1);
    start = 1; @(negedge clk); start = 0;
    chk("R1 valid drops", res_valid, 0);
    done = 1; @(negedge clk); done = 0;
    chk("R1 next result", res_code, 1);
    lat = 0;
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) begin rxm[i] = 0; cmem[i] = 0; end
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_ack_data();
    t_ack_empty();
    t_codes();
    t_priority();
    t_overflow();
    t_no_done();
    t_hold_busy();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual 1 expected 0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule